// File: doc/BRIEF.md
# Parallelism-Aware Miss Cost Accumulator

This block tracks outstanding cache misses in a small table and charges each one for the stall time it causes. In every clock cycle it splits one unit of stall cost evenly among all demand misses that are in flight. A miss that is alone gains a full cycle of cost. Misses that overlap share the cycle between them. Prefetch misses are held in the table but are never charged.

When a miss is retired, the block reduces its accumulated cost to a 3-bit cost class. It then presents that class together with the block address, so a replacement engine can use it.

Allocation uses one port that takes an address and a prefetch flag. The block answers in the same cycle with a grant and the slot index it picked. A second port retires a slot by its index. The result appears one cycle later on a registered output.

Top module: `mlp_cost_table`

## Requirements
- R1: After a synchronous active-low reset, no slot is occupied, `table_full` is 0 and `done_valid` is 0.
- R2: An allocate request is granted in the same cycle when a slot is free. `alloc_idx` then names the lowest-numbered slot that is free at the start of that cycle. A granted slot starts with a cost of zero.
- R3: Cost is unsigned fixed point with 8 fractional bits, so one full cycle is 256. A demand slot gains cost at every clock edge at which it was occupied at the start of the cycle, including the edge at which it retires. A lone demand miss therefore gains 256 per cycle.
- R4: With N demand slots occupied at the start of a cycle, each gains floor(256/N) at that edge. N counts the slots retiring in that cycle and excludes any slot being allocated in that cycle.
- R5: Prefetch slots (`alloc_prefetch`=1) never gain cost, are not counted in N, and retire with class 0.
- R6: The cost class is min(7, floor(C/60)), where C is the integer part of the final cost (cost divided by 256, rounded down).
- R7: A retire of an occupied slot frees it. One clock edge later, `done_valid` pulses for one cycle with that slot's address on `done_addr` and its class on `done_class`.
- R8: The table has 32 slots. While all are occupied, `table_full` is 1, allocate requests get no grant, and this also holds when a retire arrives in the same cycle.
- R9: A retire that names an unoccupied slot is ignored: `done_valid` stays 0 and no slot changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate request |
| alloc_addr | input | 32 | Block address of the new miss |
| alloc_prefetch | input | 1 | 1 = prefetch miss, 0 = demand miss |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_idx | output | 5 | Slot taken by a granted request |
| table_full | output | 1 | All slots occupied |
| retire_valid | input | 1 | Retire request |
| retire_idx | input | 5 | Slot to retire |
| done_valid | output | 1 | Retired result valid |
| done_addr | output | 32 | Address of the retired miss |
| done_class | output | 3 | Quantized cost class of the retired miss |

## Verification
`alloc_grant`, `alloc_idx` and `table_full` are combinational, so they are due in the cycle of the request. The bench reads them 1 ns after it drives its inputs, which is before the next clock edge. The retire result is due after exactly one edge, so the bench waits for one rising edge and samples at the following falling edge. The bench keeps a cycle-by-cycle model of the cost rules, stepped once per edge with N taken from the state before that edge, so expected classes for overlapping misses are known at the exact cycle they appear.

// File: rtl/mca_pkg.sv
// Package: shared constants and types for the miss cost accumulator.
// Assumes the cost class is a fixed 3-bit code, 0 (cheap) to 7 (costly).
package mca_pkg;
    localparam int CLASS_W     = 3;
    localparam int NUM_CLASSES = 1 << CLASS_W;
    typedef logic [CLASS_W-1:0] cost_class_t;
endpackage

// File: rtl/mca_free_finder.sv
// Finds the lowest-numbered free slot and flags a full table.
// Assumes occ_i reflects slot occupancy at the start of the cycle.
module mca_free_finder #(
    parameter int SLOTS = 32,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] occ_i,
    output logic [IDX_W-1:0] free_idx_o,
    output logic             all_busy_o
);
    // Priority pick: scan from the top so the lowest free slot wins last.
    always_comb begin
        free_idx_o = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!occ_i[i]) free_idx_o = IDX_W'(i);
        end
    end

    assign all_busy_o = &occ_i;
endmodule

// File: rtl/mca_share_lut.sv
// Counts outstanding demand misses and looks up this cycle's per-miss share.
// Assumes FRAC_W fractional bits; share is floor(2^FRAC_W / N), and 0 for N = 0.
module mca_share_lut #(
    parameter int SLOTS  = 32,
    parameter int FRAC_W = 8,
    parameter int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0]  demand_i,
    output logic [FRAC_W:0]   share_o
);
    localparam int ONE = 1 << FRAC_W;

    logic [CNT_W-1:0] n_demand;
    logic [FRAC_W:0]  lut [SLOTS+1];

    // Population count of demand slots occupied at the start of the cycle.
    always_comb begin
        n_demand = '0;
        for (int i = 0; i < SLOTS; i++) n_demand = n_demand + CNT_W'(demand_i[i]);
    end

    // Reciprocal table, one constant entry per possible count.
    assign lut[0] = '0;
    for (genvar g = 1; g <= SLOTS; g++) begin : g_recip
        assign lut[g] = (FRAC_W + 1)'(ONE / g);
    end

    assign share_o = lut[n_demand];
endmodule

// File: rtl/mca_quantizer.sv
// Maps the integer cycle count of a cost to a 3-bit class in bins of BIN_CYCLES.
// Assumes the top class absorbs every count at or above 7 bins.
module mca_quantizer #(
    parameter int INT_W      = 10,
    parameter int BIN_CYCLES = 60
) (
    input  logic [INT_W-1:0]          cycles_i,
    output mca_pkg::cost_class_t      class_o
);
    localparam int TOP = mca_pkg::NUM_CLASSES - 1;

    logic [TOP:1] at_or_above;

    // One threshold comparator per class boundary.
    for (genvar k = 1; k <= TOP; k++) begin : g_thr
        assign at_or_above[k] = int'(cycles_i) >= k * BIN_CYCLES;
    end

    // Thermometer-to-binary: the class is the number of boundaries passed.
    always_comb begin
        class_o = '0;
        for (int k = 1; k <= TOP; k++) class_o = class_o + mca_pkg::cost_class_t'(at_or_above[k]);
    end
endmodule

// File: rtl/mca_slot.sv
// One outstanding-miss slot: occupancy, kind, address and a saturating cost.
// Assumes alloc_hit only targets a free slot and retire_hit only an occupied one.
module mca_slot #(
    parameter int ADDR_W = 32,
    parameter int FRAC_W = 8,
    parameter int COST_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_hit,
    input  logic              alloc_pf,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              retire_hit,
    input  logic [FRAC_W:0]   share_i,
    output logic              occ_o,
    output logic              demand_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [COST_W-1:0] cost_final_o
);
    logic              occ_q;
    logic              pf_q;
    logic [ADDR_W-1:0] addr_q;
    logic [COST_W-1:0] cost_q;
    logic [COST_W:0]   sum;
    logic [COST_W-1:0] cost_sat;

    // Add this cycle's share and clamp at the largest code.
    always_comb begin
        sum      = {1'b0, cost_q} + (COST_W + 1)'(share_i);
        cost_sat = sum[COST_W] ? '1 : sum[COST_W-1:0];
    end

    // Slot state: load on allocate, charge demand misses, free on retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= 1'b0;
            pf_q   <= 1'b0;
            addr_q <= '0;
            cost_q <= '0;
        end else if (alloc_hit) begin
            occ_q  <= 1'b1;
            pf_q   <= alloc_pf;
            addr_q <= alloc_addr;
            cost_q <= '0;
        end else begin
            if (retire_hit) occ_q <= 1'b0;
            if (occ_q && !pf_q) cost_q <= cost_sat;
        end
    end

    assign occ_o        = occ_q;
    assign demand_o     = occ_q && !pf_q;
    assign addr_o       = addr_q;
    assign cost_final_o = demand_o ? cost_sat : cost_q;

    // R2: a fresh slot is occupied and starts from zero cost.
    assert_alloc_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_hit |=> (occ_q && cost_q == '0));

    // R5: a prefetch slot never accumulates cost.
    assert_pf_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q && pf_q && !alloc_hit) |=> $stable(cost_q));

    // R3: an occupied demand slot grows every cycle until it saturates.
    assert_demand_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q && !pf_q && !alloc_hit) |=> ((cost_q > $past(cost_q)) || (&cost_q)));
endmodule

// File: rtl/mlp_cost_table.sv
// Outstanding-miss table that charges each in-flight demand miss an equal
// share of every stall cycle and reports a 3-bit cost class on retirement.
// Assumes SLOTS is a power of two so every retire_idx value names a slot.
module mlp_cost_table #(
    parameter int SLOTS      = 32,
    parameter int ADDR_W     = 32,
    parameter int FRAC_W     = 8,
    parameter int INT_W      = 10,
    parameter int BIN_CYCLES = 60
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_valid,
    input  logic [ADDR_W-1:0]           alloc_addr,
    input  logic                        alloc_prefetch,
    output logic                        alloc_grant,
    output logic [$clog2(SLOTS)-1:0]    alloc_idx,
    output logic                        table_full,
    input  logic                        retire_valid,
    input  logic [$clog2(SLOTS)-1:0]    retire_idx,
    output logic                        done_valid,
    output logic [ADDR_W-1:0]           done_addr,
    output logic [mca_pkg::CLASS_W-1:0] done_class
);
    localparam int IDX_W  = $clog2(SLOTS);
    localparam int COST_W = INT_W + FRAC_W;

    logic [SLOTS-1:0]  occ_vec;
    logic [SLOTS-1:0]  demand_vec;
    logic [FRAC_W:0]   share;
    logic              retire_ok;
    logic [ADDR_W-1:0] slot_addr [SLOTS];
    logic [COST_W-1:0] slot_cost [SLOTS];
    mca_pkg::cost_class_t retire_class;

    // Lowest free slot and full flag from the start-of-cycle occupancy.
    mca_free_finder #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_free (
        .occ_i      (occ_vec),
        .free_idx_o (alloc_idx),
        .all_busy_o (table_full)
    );

    // Per-miss share of this cycle from the demand count.
    mca_share_lut #(.SLOTS(SLOTS), .FRAC_W(FRAC_W)) u_share (
        .demand_i (demand_vec),
        .share_o  (share)
    );

    assign alloc_grant = alloc_valid && !table_full;
    assign retire_ok   = retire_valid && occ_vec[retire_idx];

    // One slot instance per table entry.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        mca_slot #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .COST_W(COST_W)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_hit    (alloc_grant && (alloc_idx == IDX_W'(g))),
            .alloc_pf     (alloc_prefetch),
            .alloc_addr   (alloc_addr),
            .retire_hit   (retire_ok && (retire_idx == IDX_W'(g))),
            .share_i      (share),
            .occ_o        (occ_vec[g]),
            .demand_o     (demand_vec[g]),
            .addr_o       (slot_addr[g]),
            .cost_final_o (slot_cost[g])
        );
    end

    // Class of the slot being retired, including this cycle's share.
    mca_quantizer #(.INT_W(INT_W), .BIN_CYCLES(BIN_CYCLES)) u_quant (
        .cycles_i (slot_cost[retire_idx][COST_W-1:FRAC_W]),
        .class_o  (retire_class)
    );

    // Registered retire result, one pulse per accepted retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_addr  <= '0;
            done_class <= '0;
        end else begin
            done_valid <= retire_ok;
            if (retire_ok) begin
                done_addr  <= slot_addr[retire_idx];
                done_class <= retire_class;
            end
        end
    end

    // R7: a result only ever follows a retire request by one cycle.
    assert_done_after_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(retire_valid));

    // R9: a retire aimed at an empty slot yields no result.
    assert_empty_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && !occ_vec[retire_idx]) |=> !done_valid);

    // R8: a full table stays full while nothing retires.
    assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (table_full && !retire_valid) |=> table_full);

    // R2: a grant always lands on an unoccupied slot.
    assert_grant_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |-> !occ_vec[alloc_idx]);
endmodule

// File: tb/mlp_cost_table_tb_top.sv
// Self-checking bench: vector table of lone misses, then directed tests.
module mlp_cost_table_tb_top;
    localparam int SLOTS    = 32;
    localparam int ONE      = 256;
    localparam int COST_MAX = (1 << 18) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [31:0] alloc_addr = '0;
    logic        alloc_prefetch = 1'b0;
    logic        alloc_grant;
    logic [4:0]  alloc_idx;
    logic        table_full;
    logic        retire_valid = 1'b0;
    logic [4:0]  retire_idx = '0;
    logic        done_valid;
    logic [31:0] done_addr;
    logic [2:0]  done_class;

    always #10 clk = ~clk;

    mlp_cost_table dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_prefetch(alloc_prefetch),
        .alloc_grant(alloc_grant), .alloc_idx(alloc_idx), .table_full(table_full),
        .retire_valid(retire_valid), .retire_idx(retire_idx),
        .done_valid(done_valid), .done_addr(done_addr), .done_class(done_class)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    // Reference state built from the requirements.
    bit  [SLOTS-1:0] m_occ = '0;
    bit  [SLOTS-1:0] m_pf = '0;
    int          m_cost [SLOTS];
    logic [31:0] m_addr [SLOTS];

    typedef struct packed {
        logic        pf;
        logic [15:0] dur;
        logic [2:0]  cls;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd1,   3'd0},
        '{1'b0, 16'd59,  3'd0},
        '{1'b0, 16'd60,  3'd1},
        '{1'b0, 16'd119, 3'd1},
        '{1'b0, 16'd120, 3'd2},
        '{1'b0, 16'd419, 3'd6},
        '{1'b0, 16'd420, 3'd7},
        '{1'b0, 16'd600, 3'd7},
        '{1'b1, 16'd300, 3'd0},
        '{1'b0, 16'd250, 3'd4}
    };

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int quant(input int cost);
        int c;
        c = (cost / ONE) / 60;
        return (c > 7) ? 7 : c;
    endfunction

    // One clock cycle: drive inputs, check same-cycle outputs, step the model,
    // then check the registered result at the next falling edge.
    task automatic tick(input bit av, input bit apf, input logic [31:0] aaddr,
                        input bit rv, input int ridx, input string req, input bit chk_out);
        int  n;
        int  share;
        int  free_i;
        bit  full_m;
        bit  exp_out;
        int  exp_cls;
        logic [31:0] exp_addr;
        alloc_valid = av; alloc_prefetch = apf; alloc_addr = aaddr;
        retire_valid = rv; retire_idx = 5'(ridx);
        #1;
        n = 0;
        free_i = -1;
        for (int i = 0; i < SLOTS; i++) begin
            if (m_occ[i] && !m_pf[i]) n++;
            if (!m_occ[i] && free_i < 0) free_i = i;
        end
        full_m = (free_i < 0);
        share  = (n == 0) ? 0 : ONE / n;
        if (av) begin
            chk(table_full == full_m, req, "table_full", int'(table_full), int'(full_m));
            chk(alloc_grant == !full_m, req, "alloc_grant", int'(alloc_grant), int'(!full_m));
            if (!full_m) chk(int'(alloc_idx) == free_i, req, "alloc_idx", int'(alloc_idx), free_i);
        end
        exp_out = rv && m_occ[ridx];
        exp_cls = 0;
        exp_addr = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (m_occ[i] && !m_pf[i]) begin
                m_cost[i] = m_cost[i] + share;
                if (m_cost[i] > COST_MAX) m_cost[i] = COST_MAX;
            end
        end
        if (exp_out) begin
            exp_cls  = quant(m_cost[ridx]);
            exp_addr = m_addr[ridx];
            m_occ[ridx] = 1'b0;
        end
        if (av && !full_m) begin
            m_occ[free_i]  = 1'b1;
            m_pf[free_i]   = apf;
            m_cost[free_i] = 0;
            m_addr[free_i] = aaddr;
        end
        @(posedge clk);
        @(negedge clk);
        alloc_valid = 1'b0;
        retire_valid = 1'b0;
        if (chk_out) begin
            chk(done_valid == exp_out, req, "done_valid", int'(done_valid), int'(exp_out));
            if (exp_out) begin
                chk(done_addr == exp_addr, req, "done_addr", int'(done_addr), int'(exp_addr));
                chk(int'(done_class) == exp_cls, req, "done_class", int'(done_class), exp_cls);
            end
        end
    endtask

    task automatic idle(input int cycles);
        for (int c = 0; c < cycles; c++) tick(1'b0, 1'b0, '0, 1'b0, 0, "idle", 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < SLOTS; i++) begin m_cost[i] = 0; m_addr[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        chk(done_valid == 1'b0, "R1", "done_valid", int'(done_valid), 0);
        chk(table_full == 1'b0, "R1", "table_full", int'(table_full), 0);

        // R9: retire of an empty slot gives nothing.
        tick(1'b0, 1'b0, '0, 1'b1, 7, "R9", 1'b1);

        // Vector table: lone misses of varying length (R3, R5, R6, R7).
        for (int v = 0; v < NV; v++) begin
            tick(1'b1, VECS[v].pf, 32'h1000_0000 + 32'(v * 64), 1'b0, 0, "R2", 1'b0);
            idle(int'(VECS[v].dur) - 1);
            tick(1'b0, 1'b0, '0, 1'b1, 0, VECS[v].pf ? "R5" : "R6", 1'b1);
            chk(int'(done_class) == int'(VECS[v].cls), VECS[v].pf ? "R5" : "R3",
                "table class", int'(done_class), int'(VECS[v].cls));
        end

        // R4/R5: overlapping demand misses with a prefetch alongside.
        tick(1'b1, 1'b0, 32'hA000_0000, 1'b0, 0, "R4", 1'b0);
        tick(1'b1, 1'b0, 32'hA000_0040, 1'b0, 0, "R4", 1'b0);
        tick(1'b1, 1'b1, 32'hA000_0080, 1'b0, 0, "R5", 1'b0);
        tick(1'b1, 1'b0, 32'hA000_00C0, 1'b0, 0, "R4", 1'b0);
        idle(200);
        tick(1'b1, 1'b0, 32'hA000_0100, 1'b1, 0, "R4", 1'b1);
        idle(150);
        tick(1'b0, 1'b0, '0, 1'b1, 1, "R4", 1'b1);
        tick(1'b0, 1'b0, '0, 1'b1, 3, "R4", 1'b1);
        tick(1'b0, 1'b0, '0, 1'b1, 2, "R5", 1'b1);
        tick(1'b0, 1'b0, '0, 1'b1, 1, "R9", 1'b1);
        tick(1'b0, 1'b0, '0, 1'b1, 0, "R7", 1'b1);

        // R8: fill the table, then try to allocate with and without a retire.
        for (int i = 0; i < SLOTS - 1; i++) tick(1'b1, 1'b0, 32'hB000_0000 + 32'(i * 64), 1'b0, 0, "R8", 1'b0);
        #1;
        chk(table_full == 1'b1, "R8", "table_full after fill", int'(table_full), 1);
        tick(1'b1, 1'b0, 32'hC000_0000, 1'b0, 0, "R8", 1'b0);
        tick(1'b1, 1'b0, 32'hC000_0040, 1'b1, 5, "R8", 1'b1);
        #1;
        chk(table_full == 1'b0, "R8", "table_full after retire", int'(table_full), 0);
        tick(1'b1, 1'b0, 32'hC000_0080, 1'b0, 0, "R2", 1'b0);
        idle(100);
        for (int i = 0; i < SLOTS; i++) tick(1'b0, 1'b0, '0, 1'b1, i, "R7", 1'b1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule